// File: doc/BRIEF.md
# Feature-Gated Mode Configuration Register

This block is a pair of 32-bit registers that sits next to an interrupt controller and selects its optional modes. One register is a read-only capability word. The other is a writable mode word. Software may set a mode bit only if the capability word advertises it. Once the mode word has its enable bit set, the mode word is locked. The only write it then accepts is an all-zero write, which clears every mode bit and so releases the lock. Illegal writes are refused and answered with an access error.

The capability word comes from a configuration input. It is captured in the first clock cycle after reset. A marker bit is ORed into it when the extension is built in. The individual mode bits drive the controller's mode inputs directly as outputs.

When the extension is left out at build time, the window is not decoded. Every access is answered with an error and zero data. The enable output is then held at one. Every request gets exactly one response, registered one cycle after the request.

Top module: `featcfg_reg`

## Requirements
- R1: A write to the capability offset (0x00) is answered with an error, and the capability word read afterwards is unchanged.
- R2: A write to the mode offset (0x04) that carries a nonzero value while mode bit 1 (enable) is set is answered with an error, and it leaves the mode word and the mode outputs unchanged.
- R3: An accepted write to the mode offset stores the written value ANDed with the capability word, so bits that are not advertised read back as zero.
- R4: After reset the mode word reads zero, and both mode outputs are low when the extension is present.
- R5: When the extension is absent, `mode_enable_o` is 1, `mode_core_encode_o` is 0, and every access is answered with an error and zero read data.
- R6: When the extension is present, bit 0 of the capability word reads as 1, together with the bits set on `feat_cfg_i`.
- R7: A zero write to the mode offset is accepted even while enable is set, and it clears all mode bits.
- R8: The capability word is taken from `feat_cfg_i` in the first cycle after reset; later changes on that input have no effect until the next reset.
- R9: For each cycle in which `req_valid_i` is high, `rsp_valid_o` is high in the following cycle; in all other cycles it is low. Write responses carry zero data.
- R10: An access to any other offset is answered with an error and zero data, and it changes no state.
- R11: `mode_enable_o` follows mode bit 1 and `mode_core_encode_o` follows mode bit 2. Both change only after an accepted write to the mode offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| feat_cfg_i | input | 32 | Capability bits offered by the integration, captured after reset |
| req_valid_i | input | 1 | Access request this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Byte offset of the access |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_err_o | output | 1 | Access error for the answered request |
| rsp_rdata_o | output | 32 | Read data, zero for writes and errors |
| mode_enable_o | output | 1 | Enable mode bit |
| mode_core_encode_o | output | 1 | Binary core-number encoding mode bit |

## Verification
The assertions check, on every cycle, the properties that follow from a single request and the response after it. These are the one-cycle response pulse, errors on capability writes and unmapped offsets, and errors on every access when the extension is absent. They also check the refusal of nonzero writes while enabled with the mode outputs left unchanged, the unlock by a zero write, and that the mode outputs do not move without a write. Some behaviours depend on what was stored earlier, and only the bench's ordered scenarios can show them. These are the masking of stored values by the capability word, the capture of the capability word after reset while later input changes are ignored, and the read-back of the mode word after refused writes. A behavioural reference model compares every response and mode output on every clock.

// File: rtl/featcfg_pkg.sv
package featcfg_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_CAP  = 2'd1,
    ACC_MODE = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/featcfg_decode.sv
module featcfg_decode
  import featcfg_pkg::*;
#(
  parameter int             AW       = 8,
  parameter logic [AW-1:0]  CAP_OFS  = '0,
  parameter logic [AW-1:0]  MODE_OFS = '0,
  parameter bit             PRESENT  = 1'b1
) (
  input  logic [AW-1:0] addr_i,
  output acc_kind_e     kind_o
);
  generate
    if (PRESENT) begin : g_mapped
      always_comb begin
        if (addr_i == CAP_OFS)       kind_o = ACC_CAP;
        else if (addr_i == MODE_OFS) kind_o = ACC_MODE;
        else                         kind_o = ACC_NONE;
      end
    end else begin : g_unmapped
      logic unused_addr;
      assign unused_addr = ^addr_i;
      assign kind_o      = ACC_NONE;
    end
  endgenerate
endmodule

// File: rtl/featcfg_cap_latch.sv
module featcfg_cap_latch #(
  parameter int DW           = 32,
  parameter int MARK_BIT     = 0,
  parameter bit PRESENT      = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] cfg_i,
  output logic [DW-1:0] cap_o
);
  localparam logic [DW-1:0] ONE_W    = {{(DW-1){1'b0}}, 1'b1};
  localparam logic [DW-1:0] MARK_MSK = PRESENT ? (ONE_W << MARK_BIT) : '0;

  logic          taken_q, taken_d;
  logic [DW-1:0] word_q, word_d;
  logic [DW-1:0] raw;

  assign raw = cfg_i | MARK_MSK;

  always_comb begin
    taken_d = 1'b1;
    word_d  = taken_q ? word_q : raw;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_q <= 1'b0;
      word_q  <= '0;
    end else begin
      taken_q <= taken_d;
      word_q  <= word_d;
    end
  end

  assign cap_o = taken_q ? word_q : raw;
endmodule

// File: rtl/featcfg_guard.sv
module featcfg_guard
  import featcfg_pkg::*;
#(
  parameter int DW      = 32,
  parameter int EN_BIT  = 1
) (
  input  logic          valid_i,
  input  logic          write_i,
  input  acc_kind_e     kind_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] cap_i,
  input  logic [DW-1:0] mode_q_i,
  output logic          err_o,
  output logic [DW-1:0] rdata_o,
  output logic          mode_we_o,
  output logic [DW-1:0] mode_d_o
);
  logic locked;
  assign locked = mode_q_i[EN_BIT];

  always_comb begin
    err_o     = 1'b0;
    rdata_o   = '0;
    mode_we_o = 1'b0;
    mode_d_o  = wdata_i & cap_i;
    if (valid_i) begin
      unique case (kind_i)
        ACC_CAP: begin
          if (write_i) err_o   = 1'b1;
          else         rdata_o = cap_i;
        end
        ACC_MODE: begin
          if (write_i) begin
            if (locked && (wdata_i != '0)) err_o     = 1'b1;
            else                           mode_we_o = 1'b1;
          end else begin
            rdata_o = mode_q_i;
          end
        end
        default: err_o = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/featcfg_reg.sv
module featcfg_reg
  import featcfg_pkg::*;
#(
  parameter int            DW         = 32,
  parameter int            AW         = 8,
  parameter bit            EXT_PRESENT = 1'b1,
  parameter logic [AW-1:0] CAP_OFS    = 8'h00,
  parameter logic [AW-1:0] MODE_OFS   = 8'h04,
  parameter int            MARK_BIT   = 0,
  parameter int            EN_BIT     = 1,
  parameter int            ENC_BIT    = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] feat_cfg_i,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic          rsp_err_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          mode_enable_o,
  output logic          mode_core_encode_o
);
  acc_kind_e     kind;
  logic [DW-1:0] cap_word;
  logic [DW-1:0] mode_q, mode_d, mode_wval;
  logic          mode_we;
  logic          err_c;
  logic [DW-1:0] rdata_c;
  logic          rsp_v_q, rsp_e_q;
  logic [DW-1:0] rsp_d_q;

  featcfg_decode #(
    .AW(AW), .CAP_OFS(CAP_OFS), .MODE_OFS(MODE_OFS), .PRESENT(EXT_PRESENT)
  ) u_decode (
    .addr_i (req_addr_i),
    .kind_o (kind)
  );

  featcfg_cap_latch #(
    .DW(DW), .MARK_BIT(MARK_BIT), .PRESENT(EXT_PRESENT)
  ) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cfg_i  (feat_cfg_i),
    .cap_o  (cap_word)
  );

  featcfg_guard #(
    .DW(DW), .EN_BIT(EN_BIT)
  ) u_guard (
    .valid_i   (req_valid_i),
    .write_i   (req_write_i),
    .kind_i    (kind),
    .wdata_i   (req_wdata_i),
    .cap_i     (cap_word),
    .mode_q_i  (mode_q),
    .err_o     (err_c),
    .rdata_o   (rdata_c),
    .mode_we_o (mode_we),
    .mode_d_o  (mode_wval)
  );

  always_comb begin
    mode_d = mode_q;
    if (mode_we) mode_d = mode_wval;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      rsp_v_q <= 1'b0;
      rsp_e_q <= 1'b0;
      rsp_d_q <= '0;
    end else begin
      mode_q  <= mode_d;
      rsp_v_q <= req_valid_i;
      rsp_e_q <= err_c;
      rsp_d_q <= rdata_c;
    end
  end

  assign rsp_valid_o        = rsp_v_q;
  assign rsp_err_o          = rsp_e_q;
  assign rsp_rdata_o        = rsp_d_q;
  assign mode_enable_o      = EXT_PRESENT ? mode_q[EN_BIT] : 1'b1;
  assign mode_core_encode_o = mode_q[ENC_BIT];
endmodule

// File: rtl/featcfg_reg_chk.sv
module featcfg_reg_chk #(
  parameter int            DW       = 32,
  parameter int            AW       = 8,
  parameter bit            PRESENT  = 1'b1,
  parameter logic [AW-1:0] CAP_OFS  = 8'h00,
  parameter logic [AW-1:0] MODE_OFS = 8'h04
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_write_i,
  input logic [AW-1:0] req_addr_i,
  input logic [DW-1:0] req_wdata_i,
  input logic          rsp_valid_o,
  input logic          rsp_err_o,
  input logic [DW-1:0] rsp_rdata_o,
  input logic          mode_enable_o,
  input logic          mode_core_encode_o
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  logic wr_cap, wr_mode, other;
  assign wr_cap  = req_valid_i && req_write_i && (req_addr_i == CAP_OFS);
  assign wr_mode = req_valid_i && req_write_i && (req_addr_i == MODE_OFS);
  assign other   = req_valid_i && (req_addr_i != CAP_OFS) && (req_addr_i != MODE_OFS);

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    req_valid_i |=> rsp_valid_o); // R9
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    !req_valid_i |=> !rsp_valid_o); // R9
  AST_CAP_WRITE_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    wr_cap |=> rsp_err_o); // R1
  AST_UNMAPPED_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    other |=> (rsp_err_o && (rsp_rdata_o == '0))); // R10
  AST_LOCKED_REFUSE: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    (wr_mode && mode_enable_o && (req_wdata_i != '0)) |=>
      (rsp_err_o && $stable(mode_enable_o) && $stable(mode_core_encode_o))); // R2
  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    !wr_mode |=> ($stable(mode_enable_o) && $stable(mode_core_encode_o))); // R11

  generate
    if (PRESENT) begin : g_present
      AST_ZERO_UNLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
        (wr_mode && (req_wdata_i == '0)) |=>
          (!rsp_err_o && !mode_enable_o && !mode_core_encode_o)); // R7
    end else begin : g_absent
      AST_ABSENT_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
        req_valid_i |=> (rsp_err_o && (rsp_rdata_o == '0))); // R5
    end
  endgenerate
endmodule

bind featcfg_reg featcfg_reg_chk #(
  .DW(DW), .AW(AW), .PRESENT(EXT_PRESENT), .CAP_OFS(CAP_OFS), .MODE_OFS(MODE_OFS)
) u_chk (
  .clk_i              (clk_i),
  .rst_ni             (rst_ni),
  .req_valid_i        (req_valid_i),
  .req_write_i        (req_write_i),
  .req_addr_i         (req_addr_i),
  .req_wdata_i        (req_wdata_i),
  .rsp_valid_o        (rsp_valid_o),
  .rsp_err_o          (rsp_err_o),
  .rsp_rdata_o        (rsp_rdata_o),
  .mode_enable_o      (mode_enable_o),
  .mode_core_encode_o (mode_core_encode_o)
);

// File: tb/featcfg_reg_tb.sv
`timescale 1ns/1ps
module featcfg_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] feat_cfg = 32'h0000_0106;
  logic        rv = 1'b0, rw = 1'b0;
  logic [7:0]  ra = '0;
  logic [31:0] rd_w = '0;

  logic        p_v, p_e, p_en, p_enc;
  logic [31:0] p_d;
  logic        x_v, x_e, x_en, x_enc;
  logic [31:0] x_d;

  int checks = 0;
  int errors = 0;
  string cur_req = "R4";
  bit done = 0;

  always #5 clk = ~clk;

  featcfg_reg u_dut (
    .clk_i(clk), .rst_ni(rst_n), .feat_cfg_i(feat_cfg),
    .req_valid_i(rv), .req_write_i(rw), .req_addr_i(ra), .req_wdata_i(rd_w),
    .rsp_valid_o(p_v), .rsp_err_o(p_e), .rsp_rdata_o(p_d),
    .mode_enable_o(p_en), .mode_core_encode_o(p_enc));

  featcfg_reg #(.EXT_PRESENT(1'b0)) u_dut_absent (
    .clk_i(clk), .rst_ni(rst_n), .feat_cfg_i(feat_cfg),
    .req_valid_i(rv), .req_write_i(rw), .req_addr_i(ra), .req_wdata_i(rd_w),
    .rsp_valid_o(x_v), .rsp_err_o(x_e), .rsp_rdata_o(x_d),
    .mode_enable_o(x_en), .mode_core_encode_o(x_enc));

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", r, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit          m_cap;
  logic [31:0] m_feat, m_mode;
  logic        m_v, m_e;
  logic [31:0] m_d;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cap = 0; m_feat = 0; m_mode = 0; m_v = 0; m_e = 0; m_d = 0;
    end else begin
      logic [31:0] fu;
      fu = m_cap ? m_feat : (feat_cfg | 32'h1);
      if (!m_cap) begin m_feat = fu; m_cap = 1; end
      m_v = rv; m_e = 0; m_d = 0;
      if (rv) begin
        if (ra == 8'h00) begin
          if (rw) m_e = 1; else m_d = fu;
        end else if (ra == 8'h04) begin
          if (rw) begin
            if (m_mode[1] && rd_w != 0) m_e = 1;
            else m_mode = rd_w & fu;
          end else m_d = m_mode;
        end else m_e = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({cur_req, "/R9 rsp_valid"}, 32'(p_v), 32'(m_v));
      chk({cur_req, " rsp_err"}, 32'(p_e), 32'(m_e));
      chk({cur_req, " rsp_rdata"}, p_d, m_d);
      chk({cur_req, "/R11 enable"}, 32'(p_en), 32'(m_mode[1]));
      chk({cur_req, "/R11 encode"}, 32'(p_enc), 32'(m_mode[2]));
      chk("R5 absent rsp_valid", 32'(x_v), 32'(m_v));
      chk("R5 absent rsp_err", 32'(x_e), 32'(m_v));
      chk("R5 absent rdata", x_d, 32'h0);
      chk("R5 absent enable", 32'(x_en), 32'h1);
      chk("R5 absent encode", 32'(x_enc), 32'h0);
    end
  end

  logic        o_e;
  logic [31:0] o_d;
  task automatic op(input string r, input logic w, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cur_req = r;
    rv = 1'b1; rw = w; ra = a; rd_w = d;
    @(negedge clk);
    o_e = p_e; o_d = p_d;
    rv = 1'b0; rw = 1'b0; rd_w = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R4 reset rsp_valid", 32'(p_v), 32'h0);
    chk("R4 reset enable", 32'(p_en), 32'h0);
    chk("R4 reset encode", 32'(p_enc), 32'h0);
    chk("R5 reset absent enable", 32'(x_en), 32'h1);
    rst_n = 1'b1;

    op("R6", 1'b0, 8'h00, 0);          chk("R6 cap read", o_d, 32'h107);
    chk("R6 cap read err", 32'(o_e), 0);
    feat_cfg = 32'h0;
    op("R8", 1'b0, 8'h00, 0);          chk("R8 cap latched", o_d, 32'h107);
    op("R1", 1'b1, 8'h00, 32'h0);      chk("R1 cap write err", 32'(o_e), 1);
    op("R1", 1'b0, 8'h00, 0);          chk("R1 cap unchanged", o_d, 32'h107);
    op("R4", 1'b0, 8'h04, 0);          chk("R4 mode after reset", o_d, 32'h0);
    op("R3", 1'b1, 8'h04, 32'hFFFF_FFFF); chk("R3 write accepted", 32'(o_e), 0);
    chk("R11 enable set", 32'(p_en), 1);  chk("R11 encode set", 32'(p_enc), 1);
    op("R3", 1'b0, 8'h04, 0);          chk("R3 masked readback", o_d, 32'h107);
    op("R2", 1'b1, 8'h04, 32'h4);      chk("R2 locked refuse", 32'(o_e), 1);
    op("R2", 1'b0, 8'h04, 0);          chk("R2 mode unchanged", o_d, 32'h107);
    op("R7", 1'b1, 8'h04, 32'h0);      chk("R7 zero write ok", 32'(o_e), 0);
    chk("R7 enable cleared", 32'(p_en), 0);
    op("R7", 1'b0, 8'h04, 0);          chk("R7 mode cleared", o_d, 32'h0);
    op("R11", 1'b1, 8'h04, 32'h4);     chk("R11 encode only", 32'(p_enc), 1);
    chk("R11 enable stays low", 32'(p_en), 0);
    op("R3", 1'b1, 8'h04, 32'hF0F0_00F2); chk("R3 unlocked rewrite", 32'(o_e), 0);
    op("R3", 1'b0, 8'h04, 0);          chk("R3 masked value", o_d, 32'h002);
    op("R10", 1'b0, 8'h08, 0);         chk("R10 unmapped read err", 32'(o_e), 1);
    chk("R10 unmapped rdata", o_d, 32'h0);
    op("R10", 1'b1, 8'h10, 32'hFFFF_FFFF); chk("R10 unmapped write err", 32'(o_e), 1);
    op("R10", 1'b0, 8'h04, 0);         chk("R10 mode untouched", o_d, 32'h002);
    op("R7", 1'b1, 8'h04, 32'h0);
    @(negedge clk); cur_req = "R9";
    chk("R9 idle no rsp", 32'(p_v), 0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule